// File: doc/BRIEF.md
# GSM Normal Burst Assembler

This block serialises one GSM normal burst. On a start pulse it captures two 57-bit payload halves, two stealing flags and a 3-bit training-code select. It then emits the burst one bit per bit strobe. The bits come in a fixed order: a zero tail group, the first payload half, its flag, the selected 26-bit training code, the second flag, the second payload half and a closing zero tail group. Guard-period bits follow.

Each output bit comes with a one-cycle valid pulse and a field code. A downstream modulator can use the field code to ramp transmit power during the guard span, and a checker can use it to verify where each field sits. A slot is 156.25 bit periods long. To absorb the quarter bit, the guard span is 8 bits in three bursts out of four and 9 bits in the fourth. A one-cycle done pulse marks the end of the burst.

Top module: `burst_assembler`

## Requirements
- R1: After reset, busy, bit_valid, done and bit_out are 0, and field reads the guard code 0.
- R2: A start while idle captures payload_a, payload_b, steal_a, steal_b and train_sel, and busy reads 1 in the next cycle. A start while busy is ignored, and input changes after capture do not alter the burst.
- R3: Each bit_strobe seen while a burst is in progress yields exactly one output bit, with bit_valid high for the single cycle after the strobe. Without a strobe, bit_valid stays 0.
- R4: The field codes are guard=0, tail=1, data=2, flag=3, training=4. They occupy burst positions 0-2 tail, 3-59 data, 60 flag, 61-86 training, 87 flag, 88-144 data, 145-147 tail, and 148 onward guard.
- R5: Every tail bit is 0.
- R6: Positions 3-59 carry payload_a, most significant bit first. Positions 88-144 carry payload_b, most significant bit first.
- R7: Position 60 carries steal_a and position 87 carries steal_b.
- R8: Positions 61-86 carry the training code picked by train_sel, most significant bit first. The codes, in hex, are: 0:0970897, 1:0B778B7, 2:10EE90E, 3:11ED11E, 4:06B906B, 5:13AC13A, 6:29F629F, 7:3BC4BBC.
- R9: Guard bits are 0. The guard span is 8 bits, except in every fourth burst since reset (burst numbers 3, 7, ... counting from 0), where it is 9 bits.
- R10: done is high for exactly one cycle, in the cycle after the last guard bit's valid cycle. busy is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a burst when idle |
| bit_strobe | input | 1 | Advance one bit period |
| train_sel | input | 3 | Training-code select |
| payload_a | input | 57 | First payload half |
| payload_b | input | 57 | Second payload half |
| steal_a | input | 1 | Flag beside first half |
| steal_b | input | 1 | Flag beside second half |
| bit_out | output | 1 | Serial burst bit |
| bit_valid | output | 1 | One-cycle pulse per emitted bit |
| field | output | 3 | Field code of bit_out |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
The hardest case to reach is the 9-bit guard span: it depends on a slot counter that is only visible through the length of every fourth burst. The stimulus therefore runs ten complete bursts in a row from reset, so that two long bursts occur and the wrap back to short ones is also covered. Across these bursts, every training select is used, the payload patterns vary and the strobe spacing ranges from back-to-back up to three idle cycles. Every emitted bit is compared against a position model, and mid-burst start pulses together with input scrambling test that the captured values are held.

// File: rtl/burst_pkg.sv
// Shared field codes, field widths and the training-code table for the
// normal burst assembler. Assumes a 26-bit code and a 3-bit select.
package burst_pkg;
    localparam int TAIL_W = 3;
    localparam int PAY_W  = 57;
    localparam int TRN_W  = 26;
    localparam int SEL_W  = 3;

    typedef enum logic [2:0] {
        FLD_GUARD = 3'd0,
        FLD_TAIL  = 3'd1,
        FLD_DATA  = 3'd2,
        FLD_FLAG  = 3'd3,
        FLD_TRAIN = 3'd4
    } field_e;

    // Return the training code for a select value
    function automatic logic [TRN_W-1:0] train_code(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    train_code = 26'h0970897;
            3'd1:    train_code = 26'h0B778B7;
            3'd2:    train_code = 26'h10EE90E;
            3'd3:    train_code = 26'h11ED11E;
            3'd4:    train_code = 26'h06B906B;
            3'd5:    train_code = 26'h13AC13A;
            3'd6:    train_code = 26'h29F629F;
            default: train_code = 26'h3BC4BBC;
        endcase
    endfunction
endpackage

// File: rtl/burst_layout.sv
// Maps a burst position to its field code and bit value.
// Purely combinational; assumes captured operands are stable while busy.
module burst_layout
    import burst_pkg::*;
#(
    parameter int POS_W = 8
) (
    input  logic [POS_W-1:0] pos,
    input  logic [PAY_W-1:0] pay_a,
    input  logic [PAY_W-1:0] pay_b,
    input  logic             flg_a,
    input  logic             flg_b,
    input  logic [TRN_W-1:0] trn,
    output field_e           fld,
    output logic             bit_val
);
    localparam int P_D1 = TAIL_W;
    localparam int P_F1 = P_D1 + PAY_W;
    localparam int P_TR = P_F1 + 1;
    localparam int P_F2 = P_TR + TRN_W;
    localparam int P_D2 = P_F2 + 1;
    localparam int P_T2 = P_D2 + PAY_W;
    localparam int P_G  = P_T2 + TAIL_W;

    logic [PAY_W-1:0] sh_a, sh_b;
    logic [TRN_W-1:0] sh_t;
    int               p;

    // Decode the field of the current position and select its bit
    always_comb begin
        p       = int'(pos);
        sh_a    = pay_a << (p - P_D1);
        sh_b    = pay_b << (p - P_D2);
        sh_t    = trn   << (p - P_TR);
        fld     = FLD_GUARD;
        bit_val = 1'b0;
        if (p < P_D1) begin
            fld = FLD_TAIL;
        end else if (p < P_F1) begin
            fld     = FLD_DATA;
            bit_val = sh_a[PAY_W-1];
        end else if (p == P_F1) begin
            fld     = FLD_FLAG;
            bit_val = flg_a;
        end else if (p < P_F2) begin
            fld     = FLD_TRAIN;
            bit_val = sh_t[TRN_W-1];
        end else if (p == P_F2) begin
            fld     = FLD_FLAG;
            bit_val = flg_b;
        end else if (p < P_T2) begin
            fld     = FLD_DATA;
            bit_val = sh_b[PAY_W-1];
        end else if (p < P_G) begin
            fld = FLD_TAIL;
        end
    end
endmodule

// File: rtl/guard_sched.sv
// Counts bursts and gives the final position of the current burst,
// lengthening the guard by one bit once every LONG_EVERY bursts.
// Assumes advance pulses once per finished burst.
module guard_sched #(
    parameter int POS_W      = 8,
    parameter int ACTIVE     = 148,
    parameter int GUARD_BASE = 8,
    parameter int LONG_EVERY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [POS_W-1:0] last_pos
);
    localparam int SHORT_LAST = ACTIVE + GUARD_BASE - 1;

    logic long_slot;

    generate
        if (LONG_EVERY >= 2) begin : g_cnt
            localparam int CW = $clog2(LONG_EVERY);
            logic [CW-1:0] cnt;

            // Step the slot counter at the end of each burst, wrapping
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt <= '0;
                else if (advance)
                    cnt <= (int'(cnt) == LONG_EVERY - 1) ? '0 : cnt + 1'b1;
            end
            assign long_slot = (int'(cnt) == LONG_EVERY - 1);
        end else begin : g_none
            assign long_slot = 1'b0;
        end
    endgenerate

    assign last_pos = long_slot ? POS_W'(SHORT_LAST + 1) : POS_W'(SHORT_LAST);
endmodule

// File: rtl/burst_assembler.sv
// Normal burst assembler: captures payload, flags and training select on
// start, then emits one bit per strobe with a field code, and pulses done
// after the guard span. Synchronous active-low reset.
module burst_assembler
    import burst_pkg::*;
#(
    parameter int GUARD_BASE = 8,
    parameter int LONG_EVERY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bit_strobe,
    input  logic [SEL_W-1:0] train_sel,
    input  logic [PAY_W-1:0] payload_a,
    input  logic [PAY_W-1:0] payload_b,
    input  logic             steal_a,
    input  logic             steal_b,
    output logic             bit_out,
    output logic             bit_valid,
    output logic [2:0]       field,
    output logic             busy,
    output logic             done
);
    localparam int ACTIVE = 2 * TAIL_W + 2 * PAY_W + 2 + TRN_W;
    localparam int POS_W  = $clog2(ACTIVE + GUARD_BASE + 2);

    logic [POS_W-1:0] pos, last_pos;
    logic [PAY_W-1:0] cap_a, cap_b;
    logic [TRN_W-1:0] cap_t;
    logic             cap_fa, cap_fb, fin, cur_bit;
    field_e           cur_fld;

    burst_layout #(.POS_W(POS_W)) u_layout (
        .pos(pos), .pay_a(cap_a), .pay_b(cap_b), .flg_a(cap_fa),
        .flg_b(cap_fb), .trn(cap_t), .fld(cur_fld), .bit_val(cur_bit)
    );

    guard_sched #(
        .POS_W(POS_W), .ACTIVE(ACTIVE),
        .GUARD_BASE(GUARD_BASE), .LONG_EVERY(LONG_EVERY)
    ) u_sched (
        .clk(clk), .rst_n(rst_n), .advance(busy & fin), .last_pos(last_pos)
    );

    // Burst control: capture, per-strobe emission and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            fin       <= 1'b0;
            pos       <= '0;
            cap_a     <= '0;
            cap_b     <= '0;
            cap_t     <= '0;
            cap_fa    <= 1'b0;
            cap_fb    <= 1'b0;
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
            field     <= FLD_GUARD;
            done      <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            done      <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    pos    <= '0;
                    cap_a  <= payload_a;
                    cap_b  <= payload_b;
                    cap_t  <= train_code(train_sel);
                    cap_fa <= steal_a;
                    cap_fb <= steal_b;
                end
            end else if (fin) begin
                fin  <= 1'b0;
                busy <= 1'b0;
                done <= 1'b1;
            end else if (bit_strobe) begin
                bit_out   <= cur_bit;
                field     <= cur_fld;
                bit_valid <= 1'b1;
                if (pos == last_pos)
                    fin <= 1'b1;
                else
                    pos <= pos + 1'b1;
            end
        end
    end
endmodule

// File: rtl/burst_assembler_chk.sv
// Property checker for the burst assembler, bound to every instance.
module burst_assembler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       bit_strobe,
    input logic       bit_out,
    input logic       bit_valid,
    input logic [2:0] field,
    input logic       busy,
    input logic       done
);
    // R3
    valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(bit_strobe) && busy);
    // R2
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R5
    tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && field == 3'd1) |-> !bit_out);
    // R4
    field_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> field <= 3'd4);
    // R10
    done_after_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bit_valid) && $past(field) == 3'd0 && !busy);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind burst_assembler burst_assembler_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_strobe(bit_strobe),
    .bit_out(bit_out), .bit_valid(bit_valid), .field(field),
    .busy(busy), .done(done)
);

// File: tb/burst_assembler_test.sv
// Sweeps ten bursts over all training selects, varied payloads and strobe
// spacings, checking each emitted bit against a position model.
module burst_assembler_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, bit_strobe = 1'b0;
    logic [2:0]  train_sel = '0;
    logic [56:0] payload_a = '0, payload_b = '0;
    logic        steal_a = 1'b0, steal_b = 1'b0;
    logic        bit_out, bit_valid, busy, done;
    logic [2:0]  field;
    int          checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    burst_assembler uut (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_strobe(bit_strobe),
        .train_sel(train_sel), .payload_a(payload_a), .payload_b(payload_b),
        .steal_a(steal_a), .steal_b(steal_b), .bit_out(bit_out),
        .bit_valid(bit_valid), .field(field), .busy(busy), .done(done)
    );

    function automatic logic [25:0] tcode(input int s);
        logic [25:0] t [8] = '{26'h0970897, 26'h0B778B7, 26'h10EE90E, 26'h11ED11E,
                               26'h06B906B, 26'h13AC13A, 26'h29F629F, 26'h3BC4BBC};
        return t[s];
    endfunction

    function automatic logic [2:0] exp_field(input int p);
        if (p < 3)        return 3'd1;
        else if (p < 60)  return 3'd2;
        else if (p == 60) return 3'd3;
        else if (p < 87)  return 3'd4;
        else if (p == 87) return 3'd3;
        else if (p < 145) return 3'd2;
        else if (p < 148) return 3'd1;
        return 3'd0;
    endfunction

    function automatic logic exp_bit(input int p, input logic [56:0] a, input logic [56:0] b,
                                     input logic fa, input logic fb, input logic [25:0] t);
        if (p >= 3 && p < 60)   return a[56 - (p - 3)];
        if (p == 60)            return fa;
        if (p >= 61 && p < 87)  return t[25 - (p - 61)];
        if (p == 87)            return fb;
        if (p >= 88 && p < 145) return b[56 - (p - 88)];
        return 1'b0;
    endfunction

    function automatic logic [56:0] pat(input int k, input int h);
        logic [63:0] m = 64'h9E3779B97F4A7C15 * 64'(k * 2 + h + 1);
        case (k % 4)
            0: return '1;
            1: return '0;
            2: return {28'(0), 29'h0} | (h != 0 ? {19{3'b011}} : {19{3'b101}});
            default: return m[56:0];
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_burst(input int k, input int gap);
        logic [56:0] a = pat(k, 0), b = pat(k, 1);
        logic fa = k[0], fb = ~k[1];
        logic [25:0] t = tcode(k % 8);
        int len = 148 + ((k % 4 == 3) ? 9 : 8);
        @(negedge clk);
        payload_a = a; payload_b = b; steal_a = fa; steal_b = fb;
        train_sel = 3'(k % 8); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", 64'(busy), 64'd1);
        payload_a = ~a; payload_b = ~b; steal_a = ~fa; steal_b = ~fb;
        train_sel = 3'(k + 3);
        for (int p = 0; p < len; p++) begin
            bit_strobe = 1'b1;
            @(negedge clk);
            bit_strobe = 1'b0;
            chk("R3 valid", 64'(bit_valid), 64'd1);
            chk("R4 field", 64'(field), 64'(exp_field(p)));
            chk("R5/R6/R7/R8/R9 bit", 64'(bit_out), 64'(exp_bit(p, a, b, fa, fb, t)));
            chk("R10 no early done", 64'(done), 64'd0);
            for (int g = 0; g < gap; g++) begin
                if (p == 40 && g == 0) start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                chk("R3 no valid without strobe", 64'(bit_valid), 64'd0);
                if (p == len - 1) break;
            end
            if (p == len - 1 && gap == 0) @(negedge clk);
        end
        chk("R10 done pulse", 64'(done), 64'd1);
        chk("R10 busy low", 64'(busy), 64'd0);
        chk("R9 guard length: no extra bit", 64'(bit_valid), 64'd0);
        @(negedge clk);
        chk("R10 done single", 64'(done), 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 valid", 64'(bit_valid), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 bit", 64'(bit_out), 64'd0);
        chk("R1 field", 64'(field), 64'd0);
        rst_n = 1'b1;
        bit_strobe = 1'b1;
        @(negedge clk);
        bit_strobe = 1'b0;
        chk("R3 strobe while idle", 64'(bit_valid), 64'd0);
        for (int k = 0; k < 10; k++) run_burst(k, k % 4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule